// File: doc/BRIEF.md
# Soft-Start Reference Code Ramp

This block generates the digital input code for the reference DAC of a converter's main error amplifier. When the converter is enabled, the code starts at zero. It then rises by a fixed increment once every step period until it reaches a trimmed target code, and it holds that value from then on. The slow rise keeps the regulation loop from saturating at maximum duty cycle at power-up and stops the output from overshooting.

A single-cycle start pulse begins a ramp, and every later start pulse begins a new one from zero. The trimmed target is captured when the start pulse is accepted, so the ramp cannot move backward if the trim changes while it is running. An abort input sends the code back to zero on the next clock. The last step is clipped to the target, so the code never passes it. A done flag rises in the same cycle in which the code reaches the target.

The step period is a whole number of clock cycles set by a parameter. With the defaults (8-bit code, increment 4, 12500 cycles at 100 MHz), a full-scale target takes 64 steps of 125 µs each, about 8 ms in total.

Top module: `softstart_ramp`

## Requirements
- R1: While reset is low and after reset is released with no start pulse, the code is 0 and done is 0.
- R2: A start pulse sets the code to 0 at the next clock. After each further TICK_CYCLES clocks the code rises by STEP, so at clock c after the start the code is min((c / TICK_CYCLES) * STEP, target), using integer division.
- R3: From one cycle to the next, while neither start nor abort is applied, the code never decreases and never rises by more than STEP.
- R4: The code never goes above the captured target. The step that would pass the target loads the target exactly, and done becomes 1 in that same cycle.
- R5: Once done is 1, code and done stay unchanged until a start or abort pulse.
- R6: Abort sets the code to 0 and done to 0 at the next clock, and the block then stays idle at 0. When abort and start are both high in the same cycle, abort wins.
- R7: A start pulse during a ramp, or after done, restarts the ramp from code 0 with done at 0.
- R8: The target is captured in the cycle the start pulse is accepted. Changes to the target input after that have no effect on the running ramp or its final value.
- R9: A target below STEP, including 0, ends the ramp at the first step period with the code equal to the target. A target that is an exact multiple of STEP ends on that value, with no extra step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Enable pulse; begins a ramp from zero |
| abort | input | 1 | Returns the code to zero and stops the ramp; takes priority over start |
| target | input | CODE_W | Trimmed final code, captured when start is accepted |
| code | output | CODE_W | Present reference code for the DAC |
| done | output | 1 | High once the code equals the captured target |

## Verification
The ramp is driven with a full-scale target, a target that is an exact multiple of the increment, a target that is not, a target of zero and targets at or below one increment. Comparing the code on every cycle against the closed-form staircase shows three things: whether the step period is correct, whether the final step is clipped instead of overshooting, and whether the ramp takes one step too many on exact multiples. Directed sequences apply abort in the middle of a ramp, abort together with start, a restart during a ramp and after done, and a target change while a ramp is running. These separate a restart from zero from a resume, and a captured target from a live one.

// File: rtl/softstart_ramp.sv
module softstart_ramp #(
  parameter int CODE_W      = 8,
  parameter int STEP        = 4,
  parameter int TICK_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  localparam int SUM_W = CODE_W + 1;
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TICK_CYCLES - 1);
  localparam logic [SUM_W-1:0]  STEP_S   = SUM_W'(STEP);
  localparam logic [CODE_W-1:0] STEP_C   = CODE_W'(STEP);

  logic              running;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] goal;
  logic [CODE_W-1:0] code_q;
  logic              done_q;

  wire              tick  = running && (cnt == CNT_LAST);
  wire [SUM_W-1:0]  nxt   = {1'b0, code_q} + STEP_S;
  wire              reach = nxt >= {1'b0, goal};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      goal    <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else if (abort) begin
      running <= 1'b0;
      cnt     <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      goal    <= target;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else if (running) begin
      if (tick) begin
        cnt <= '0;
        if (reach) begin
          code_q  <= goal;
          done_q  <= 1'b1;
          running <= 1'b0;
        end else begin
          code_q <= nxt[CODE_W-1:0];
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign code = code_q;
  assign done = done_q;

  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && !start) |=> (code >= $past(code))); // R3

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && !start) |=> ((code - $past(code)) <= STEP_C)); // R3

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    code <= goal); // R4

  AST_DONE_AT_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (code == goal)); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort && !start) |=> (done && $stable(code))); // R5

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (code == '0 && !done)); // R6

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (code == '0 && !done)); // R7

endmodule

// File: tb/softstart_ramp_tb.sv
module softstart_ramp_tb;
  localparam int W = 8;
  localparam int S = 4;
  localparam int N = 4;
  localparam int NV = 6;
  localparam int VEC_TGT [NV] = '{255, 128, 130, 0, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [W-1:0] target = '0;
  logic [W-1:0] code;
  logic done;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  softstart_ramp #(.CODE_W(W), .STEP(S), .TICK_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .target(target), .code(code), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      report();
    end
  end

  function automatic int exp_code(input int c, input int tgt);
    int v = (c / N) * S;
    return (v > tgt) ? tgt : v;
  endfunction

  task automatic pulse_start(input int tgt);
    target = W'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input int tgt);
    int steps = (tgt + S - 1) / S;
    int prev = 0;
    if (steps == 0) steps = 1;
    pulse_start(tgt);
    chk("R2 start code", int'(code), 0);
    for (int c = 1; c <= N * (steps + 2); c++) begin
      @(negedge clk);
      chk((tgt < S || tgt % S == 0) ? "R9 code" : "R2/R4 code", int'(code), exp_code(c, tgt));
      chk(((c / N) * S >= tgt && c > N * steps) ? "R5 done" : "R4 done",
          int'(done), int'(c >= N && (c / N) * S >= tgt));
      chk("R3 monotonic", int'(int'(code) >= prev && int'(code) - prev <= S), 1);
      prev = int'(code);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(code), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    target = 8'd200;
    repeat (2 * N) @(negedge clk);
    chk("R1 idle code", int'(code), 0);
    chk("R1 idle done", int'(done), 0);

    for (int v = 0; v < NV; v++) run_vec(VEC_TGT[v]);

    pulse_start(255);
    repeat (10) @(negedge clk);
    chk("R2 mid ramp", int'(code), 8);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R6 abort code", int'(code), 0);
    chk("R6 abort done", int'(done), 0);
    repeat (3 * N) @(negedge clk);
    chk("R6 idle after abort", int'(code), 0);

    pulse_start(255);
    repeat (2 * N) @(negedge clk);
    target = 8'd255;
    abort = 1'b1;
    start = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    start = 1'b0;
    chk("R6 abort beats start", int'(code), 0);
    repeat (2 * N) @(negedge clk);
    chk("R6 no ramp after abort+start", int'(code), 0);
    chk("R6 done low", int'(done), 0);

    pulse_start(255);
    repeat (5 * N) @(negedge clk);
    chk("R7 before restart", int'(code), 20);
    pulse_start(255);
    chk("R7 restart code", int'(code), 0);
    repeat (N - 1) @(negedge clk);
    chk("R7 restart holds zero", int'(code), 0);
    @(negedge clk);
    chk("R7 restart first step", int'(code), S);

    pulse_start(3);
    repeat (N) @(negedge clk);
    chk("R9 small target done", int'(done), 1);
    pulse_start(3);
    chk("R7 restart after done code", int'(code), 0);
    chk("R7 restart after done flag", int'(done), 0);

    pulse_start(8);
    target = 8'd255;
    repeat (2 * N) @(negedge clk);
    chk("R8 captured target code", int'(code), 8);
    chk("R8 captured target done", int'(done), 1);
    repeat (4 * N) @(negedge clk);
    chk("R8 target change ignored", int'(code), 8);
    chk("R5 hold done", int'(done), 1);

    report();
  end
endmodule